// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a bank of general-purpose I/O lines reached through a small word-addressed register port. Software writes single-cycle write strobes and single-cycle read strobes. Each line can be set as an input or as an output. Output lines drive a data-out value. A line can also blink, which flips its pin at a rate set by an on-block prescaler.

Input pins pass through a two-stage synchroniser. A per-line polarity bit then inverts them, and the result is the data-in value. Interrupts are derived from that inverted value in two ways. The level path is unlatched: it is data-in ANDed with a level enable. The edge path latches each 0-to-1 change of data-in into a cause register. Software clears that register by writing zeros to the bits it wants cleared. Each group of eight consecutive lines shares one interrupt output, which is the OR of the enabled level and edge terms for those lines.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, all lines are inputs, so `pinOe` is all zero. Data-out, blink, polarity, both enables and the edge cause all hold zero. Every `irq` bit is low.
- R2: Register `dirCfg` sits at byte offset 0x04. A bit of 1 makes that line an input and a bit of 0 makes it an output. `pinOe[i]` equals the inverse of `dirCfg[i]`.
- R3: A read of offset 0x10 returns the pin value after a two-flop synchroniser, XORed with the polarity register at offset 0x0C. A pin change therefore appears in this read after two clock edges. Writes to offset 0x10 have no effect.
- R4: The level term of line i is data-in[i] AND level-enable[i], where level-enable is at offset 0x1C. The term is not latched: the interrupt drops once the inverted input falls.
- R5: Cause bit i (offset 0x14) is set on the clock edge after data-in[i] goes from 0 to 1. A polarity of 0 therefore catches rising pin edges, and a polarity of 1 catches falling pin edges.
- R6: A write to offset 0x14 clears each cause bit written as 0 and leaves each bit written as 1 unchanged. If a new edge arrives in the same cycle as a clear, the bit is set.
- R7: The edge term of line i is cause[i] AND edge-enable[i], where edge-enable is at offset 0x18. A cause bit that is not enabled raises no interrupt but stays readable.
- R8: `irq[g]` is the OR of the level and edge terms of lines 8g to 8g+7.
- R9: `pinOut[i]` equals data-out[i] (offset 0x00) XOR (blink-enable[i] (offset 0x08) AND a shared toggle). The toggle flips once every `BLINK_DIV` clock cycles.
- R10: Offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C read back the last value written. Unaligned offsets and offsets at 0x20 or above read as zero and are not written. Read data is registered: `rdata` changes on the clock edge that samples `rdEn` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pinIn | input | 32 | Raw input pins, asynchronous |
| pinOut | output | 32 | Pin output values |
| pinOe | output | 32 | Pin output enables, active high |
| irq | output | 4 | One interrupt per group of eight lines |

## Verification
The bench builds the bank with its default 32 lines in groups of eight, so all four interrupt outputs are driven. The blink divider is set to 6, so several full blink periods fit in a few dozen cycles and the toggle rate can be counted exactly. With these values the bench can place a pin edge in the same cycle as a cause clear, to test that the set wins. It can also flip polarity with the pin held steady, to test the falling-edge mode and the resulting spurious latch, and it runs every line against the per-cycle reference model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register index = byte offset [4:2]; software depends on this order.
  typedef enum logic [2:0] {
    SEL_DOUT   = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_BLINK  = 3'd2,
    SEL_POL    = 3'd3,
    SEL_DIN    = 3'd4,
    SEL_CAUSE  = 3'd5,
    SEL_EDGEEN = 3'd6,
    SEL_LVLEN  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrDout;
    logic    wrDir;
    logic    wrBlink;
    logic    wrPol;
    logic    wrCause;
    logic    wrEdgeEn;
    logic    wrLvlEn;
    logic    rdStrobe;
    logic    rdHit;
    regSel_e rdSel;
  } bankStrobes_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobes_t      stb
);

  localparam int MAP_BYTES = 32;

  logic    mapped;
  regSel_e sel;

  assign mapped = (addr[1:0] == 2'b00) && ((addr >> $clog2(MAP_BYTES)) == '0);
  assign sel    = regSel_e'(addr[4:2]);

  always_comb begin
    stb          = '0;
    stb.rdStrobe = rdEn;
    stb.rdHit    = rdEn && mapped;
    stb.rdSel    = sel;
    if (wrEn && mapped) begin
      unique case (sel)
        SEL_DOUT:   stb.wrDout   = 1'b1;
        SEL_DIR:    stb.wrDir    = 1'b1;
        SEL_BLINK:  stb.wrBlink  = 1'b1;
        SEL_POL:    stb.wrPol    = 1'b1;
        SEL_CAUSE:  stb.wrCause  = 1'b1;
        SEL_EDGEEN: stb.wrEdgeEn = 1'b1;
        SEL_LVLEN:  stb.wrLvlEn  = 1'b1;
        default:    ;
      endcase
    end
  end

  // R10: a single write reaches at most one register
  assert_one_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrDout, stb.wrDir, stb.wrBlink, stb.wrPol,
              stb.wrCause, stb.wrEdgeEn, stb.wrLvlEn}));

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int BLINK_DIV  = 50000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrobes_t          stb,
  input  logic [NUM_LINES-1:0]  wdata,
  input  logic [NUM_LINES-1:0]  pinIn,
  output logic [NUM_LINES-1:0]  rdata,
  output logic [NUM_LINES-1:0]  pinOut,
  output logic [NUM_LINES-1:0]  pinOe,
  output logic [NUM_LINES/GROUP_SIZE-1:0] irq
);

  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;
  localparam int CNT_W      = $clog2(BLINK_DIV);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_DIV - 1);

  logic [NUM_LINES-1:0] doutQ, dirQ, blinkQ, polQ, edgeEnQ, lvlEnQ, causeQ;
  logic [NUM_LINES-1:0] syncA, syncB, prevIn, rdataQ;
  logic [NUM_LINES-1:0] dataIn, riseVec, irqVec, readVal;
  logic [CNT_W-1:0]     prescQ;
  logic                 toggleQ, prescWrap;

  // Inverted, synchronised input and its rising-change detector
  assign dataIn  = syncB ^ polQ;
  assign riseVec = dataIn & ~prevIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevIn <= '0;
    end else begin
      syncA  <= pinIn;
      syncB  <= syncA;
      prevIn <= dataIn;
    end
  end

  // Software-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doutQ   <= '0;
      dirQ    <= '1;
      blinkQ  <= '0;
      polQ    <= '0;
      edgeEnQ <= '0;
      lvlEnQ  <= '0;
      causeQ  <= '0;
    end else begin
      if (stb.wrDout)   doutQ   <= wdata;
      if (stb.wrDir)    dirQ    <= wdata;
      if (stb.wrBlink)  blinkQ  <= wdata;
      if (stb.wrPol)    polQ    <= wdata;
      if (stb.wrEdgeEn) edgeEnQ <= wdata;
      if (stb.wrLvlEn)  lvlEnQ  <= wdata;
      causeQ <= (stb.wrCause ? (causeQ & wdata) : causeQ) | riseVec;
    end
  end

  // Blink prescaler
  assign prescWrap = (prescQ == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescQ  <= '0;
      toggleQ <= 1'b0;
    end else if (prescWrap) begin
      prescQ  <= '0;
      toggleQ <= ~toggleQ;
    end else begin
      prescQ  <= prescQ + 1'b1;
    end
  end

  assign pinOut = doutQ ^ (blinkQ & {NUM_LINES{toggleQ}});
  assign pinOe  = ~dirQ;

  // Interrupt combination per group
  assign irqVec = (dataIn & lvlEnQ) | (causeQ & edgeEnQ);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign irq[g] = |irqVec[g*GROUP_SIZE +: GROUP_SIZE];
  end

  // Read path
  always_comb begin
    unique case (stb.rdSel)
      SEL_DOUT:   readVal = doutQ;
      SEL_DIR:    readVal = dirQ;
      SEL_BLINK:  readVal = blinkQ;
      SEL_POL:    readVal = polQ;
      SEL_DIN:    readVal = dataIn;
      SEL_CAUSE:  readVal = causeQ;
      SEL_EDGEEN: readVal = edgeEnQ;
      SEL_LVLEN:  readVal = lvlEnQ;
      default:    readVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdataQ <= '0;
    else if (stb.rdStrobe) rdataQ <= stb.rdHit ? readVal : '0;
  end

  assign rdata = rdataQ;

  // R5: a cause bit only appears where data-in rose in the previous cycle
  assert_cause_from_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((causeQ & ~$past(causeQ) & ~$past(riseVec)) == '0));

  // R6: bits written as zero are gone unless a new edge arrived
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCause |=> ((causeQ & ~$past(wdata) & ~$past(riseVec)) == '0));

  // R4: with both enables empty no interrupt is raised
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lvlEnQ == '0 && edgeEnQ == '0) |-> (irq == '0));

  // R9: the blink toggle moves only when the prescaler wraps
  assert_toggle_on_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !prescWrap |=> $stable(toggleQ));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 6,
  parameter int BLINK_DIV  = 50000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_LINES-1:0]  wdata,
  output logic [NUM_LINES-1:0]  rdata,
  input  logic [NUM_LINES-1:0]  pinIn,
  output logic [NUM_LINES-1:0]  pinOut,
  output logic [NUM_LINES-1:0]  pinOe,
  output logic [NUM_LINES/GROUP_SIZE-1:0] irq
);

  bankStrobes_t stb;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .stb  (stb)
  );

  gpio_bank_datapath #(
    .NUM_LINES  (NUM_LINES),
    .GROUP_SIZE (GROUP_SIZE),
    .BLINK_DIV  (BLINK_DIV)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (wdata),
    .pinIn  (pinIn),
    .rdata  (rdata),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irq    (irq)
  );

endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;

  localparam int DIV = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pinIn = '0;
  logic [31:0] rdata, pinOut, pinOe;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_irq_bank #(.BLINK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mOut, mDir, mBlink, mPol, mEdgeEn, mLvlEn, mCause;
  logic [31:0] mS1, mS2, mPrev, mRd, mDin, mRise, mNext;
  int          mCnt;
  logic        mTog;

  function automatic logic [31:0] modelRead(input logic [5:0] a, input logic [31:0] din);
    if (a[1:0] != 2'b00 || a >= 6'h20) return '0;
    case (a)
      6'h00: return mOut;
      6'h04: return mDir;
      6'h08: return mBlink;
      6'h0C: return mPol;
      6'h10: return din;
      6'h14: return mCause;
      6'h18: return mEdgeEn;
      default: return mLvlEn;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOut = '0; mDir = '1; mBlink = '0; mPol = '0; mEdgeEn = '0; mLvlEn = '0;
      mCause = '0; mS1 = '0; mS2 = '0; mPrev = '0; mRd = '0; mCnt = 0; mTog = 0;
    end else begin
      mDin  = mS2 ^ mPol;
      mRise = mDin & ~mPrev;
      mNext = (wrEn && addr == 6'h14) ? (mCause & wdata) : mCause;
      mNext = mNext | mRise;
      if (rdEn) mRd = modelRead(addr, mDin);
      if (wrEn) begin
        case (addr)
          6'h00: mOut = wdata;
          6'h04: mDir = wdata;
          6'h08: mBlink = wdata;
          6'h0C: mPol = wdata;
          6'h18: mEdgeEn = wdata;
          6'h1C: mLvlEn = wdata;
          default: ;
        endcase
      end
      mCause = mNext;
      mPrev  = mDin;
      mS2    = mS1;
      mS1    = pinIn;
      if (mCnt == DIV - 1) begin mCnt = 0; mTog = ~mTog; end
      else mCnt++;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [31:0] v;
      logic [3:0]  eIrq;
      v = ((mS2 ^ mPol) & mLvlEn) | (mCause & mEdgeEn);
      for (int g = 0; g < 4; g++) eIrq[g] = |v[g*8 +: 8];
      chk("R2 model pinOe", pinOe, ~mDir);
      chk("R9 model pinOut", pinOut, mOut ^ (mBlink & {32{mTog}}));
      chk("R8 model irq", {28'd0, irq}, {28'd0, eIrq});
      chk("R10 model rdata", rdata, mRd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        prevBit;
    int          flips;

    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq", {28'd0, irq}, 32'd0);
    chk("R1 pinOe", pinOe, 32'd0);
    chk("R1 pinOut", pinOut, 32'd0);
    rd(6'h04, v); chk("R1 dir all inputs", v, 32'hFFFF_FFFF);
    rd(6'h14, v); chk("R1 cause", v, 32'd0);
    rd(6'h18, v); chk("R1 edge enable", v, 32'd0);
    rd(6'h1C, v); chk("R1 level enable", v, 32'd0);

    // R2 direction, R10 readback
    wr(6'h00, 32'hA5A5_0F0F);
    wr(6'h04, 32'hFFFF_0000);
    chk("R2 pinOe", pinOe, 32'h0000_FFFF);
    chk("R9 pinOut no blink", pinOut, 32'hA5A5_0F0F);
    rd(6'h00, v); chk("R10 dout readback", v, 32'hA5A5_0F0F);
    rd(6'h04, v); chk("R10 dir readback", v, 32'hFFFF_0000);

    // R3 data-in with polarity; writes ignored
    pinIn = 32'h1234_5678;
    idle(3);
    rd(6'h10, v); chk("R3 data-in", v, 32'h1234_5678);
    wr(6'h0C, 32'hFFFF_0000);
    rd(6'h10, v); chk("R3 data-in inverted", v, 32'hEDCB_5678);
    wr(6'h10, 32'hDEAD_BEEF);
    rd(6'h10, v); chk("R3 write ignored", v, 32'hEDCB_5678);
    rd(6'h0C, v); chk("R10 pol readback", v, 32'hFFFF_0000);

    wr(6'h0C, 32'd0);
    pinIn = 32'd0;
    idle(4);
    wr(6'h14, 32'd0);
    rd(6'h14, v); chk("R6 clear all", v, 32'd0);

    // R4 level path, R8 grouping
    wr(6'h1C, 32'h0000_0100);
    pinIn = 32'h0000_0100;
    idle(3);
    chk("R4 level high group1", {28'd0, irq}, 32'h2);
    pinIn = 32'd0;
    idle(3);
    chk("R4 level unlatched", {28'd0, irq}, 32'h0);
    wr(6'h1C, 32'hFFFF_FFFF);
    pinIn = 32'h0002_0000;
    idle(3);
    chk("R8 line17 to irq2", {28'd0, irq}, 32'h4);
    pinIn = 32'd0;
    wr(6'h1C, 32'd0);
    idle(3);
    wr(6'h14, 32'd0);

    // R5 rising edge, R7 latch, R6 partial clear
    wr(6'h18, 32'h8000_0000);
    pinIn = 32'h8000_0000;
    idle(3);
    chk("R5 rising edge irq3", {28'd0, irq}, 32'h8);
    pinIn = 32'd0;
    idle(3);
    chk("R7 edge stays latched", {28'd0, irq}, 32'h8);
    rd(6'h14, v); chk("R5 cause bit31", v, 32'h8000_0000);
    wr(6'h14, 32'h7FFF_FFFF);
    chk("R6 zero bit clears", {28'd0, irq}, 32'h0);
    pinIn = 32'h0000_0001;
    idle(3);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h14, v); chk("R6 ones keep", v, 32'h0000_0001);
    pinIn = 32'd0;
    idle(3);
    wr(6'h14, 32'd0);

    // R5 falling mode via polarity
    wr(6'h0C, 32'h8000_0000);
    idle(2);
    wr(6'h14, 32'd0);
    idle(1);
    pinIn = 32'h8000_0000;
    idle(3);
    rd(6'h14, v); chk("R5 pol1 ignores rise", v, 32'd0);
    pinIn = 32'd0;
    idle(3);
    rd(6'h14, v); chk("R5 pol1 catches fall", v, 32'h8000_0000);
    chk("R7 enabled edge irq", {28'd0, irq}, 32'h8);
    wr(6'h18, 32'd0);
    chk("R7 masked edge quiet", {28'd0, irq}, 32'h0);
    rd(6'h14, v); chk("R7 masked cause kept", v, 32'h8000_0000);

    // R6 set wins over same-cycle clear
    wr(6'h0C, 32'd0);
    idle(3);
    wr(6'h14, 32'd0);
    idle(1);
    pinIn = 32'h0000_0001;
    @(negedge clk);
    @(negedge clk);
    wr(6'h14, 32'd0);
    rd(6'h14, v); chk("R6 set wins", v, 32'h0000_0001);

    // R9 blink
    wr(6'h04, ~(32'h1 << 20));
    wr(6'h00, 32'd0);
    wr(6'h08, 32'h1 << 20);
    chk("R2 line20 output", pinOe, 32'h1 << 20);
    rd(6'h08, v); chk("R10 blink readback", v, 32'h1 << 20);
    prevBit = pinOut[20];
    flips = 0;
    for (int i = 0; i < 4 * DIV; i++) begin
      @(negedge clk);
      if (pinOut[20] != prevBit) flips++;
      prevBit = pinOut[20];
      chk("R9 other lines steady", pinOut & ~(32'h1 << 20), 32'd0);
    end
    chk("R9 toggle count", flips, 32'd4);

    // R10 unmapped offsets
    wr(6'h24, 32'h5555_5555);
    rd(6'h24, v); chk("R10 unmapped zero", v, 32'd0);
    rd(6'h02, v); chk("R10 unaligned zero", v, 32'd0);
    rd(6'h00, v); chk("R10 dout untouched", v, 32'd0);
    idle(2);
    chk("R10 rdata holds", rdata, 32'd0);

    done = 1;
    summary();
    $finish;
  end

endmodule